// File: doc/BRIEF.md
# Horizontal Polyphase Scaling Filter

This block resamples one image line of signed fixed-point pixels in the horizontal direction. Pixels arrive one at a time over a valid/ready input and pass through a four-entry window. For every output sample, a phase accumulator picks one of eight banks of four coefficients. The block multiplies the window by that bank, sums the products, truncates the sum and clamps it to ±1.0. The result leaves over a valid/ready output. The same datapath covers enlargement, where one window gives several outputs, and reduction, where several inputs are taken before the next output. Upstream logic only programs the step and the coefficient banks.

The accumulator holds a position in 3.13 fixed point. The top three fraction bits name the phase. After each output the step is added, and the integer part of the sum is the number of pixels to take in before the next output. A step of 0x2000 means 1.0. The valid steps run from 0x0800 (4× enlargement) to 0x8000 (4× reduction). A line may hold up to 1280 pixels. The pixel flagged as last closes the line: once its outputs are sent, the window is zeroed and the accumulator waits to reload from the start phase on the next line's first pixel.

The controller is a two-state machine:
- ST_WAIT: the input is ready.
- ST_EMIT: an output is valid.

It has five transitions:
- WAIT→EMIT (take-and-emit): a pixel is taken and its remaining skip count was one.
- WAIT→WAIT (skip): a pixel is taken while more pixels are owed.
- EMIT→EMIT (repeat): an output is taken and the new integer part is zero.
- EMIT→WAIT (advance): an output is taken and the integer part is non-zero.
- Line restart: taken from either state when the line's last pixel has been consumed. It returns to ST_WAIT, clears the window and arms the start-phase reload.

Top module: `hps_scaler`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0, and all coefficients are zero, so outputs of an unprogrammed filter are 0.
- R2: A write with cfg_we=1 stores cfg_data into the coefficient with phase cfg_addr[4:2] and tap cfg_addr[1:0]. Tap 0 multiplies the newest pixel in the window, and tap 3 the oldest.
- R3: Each output equals floor(Σ c[phase][t]·w[t] / 1024), where pixels and coefficients are 12-bit two's-complement Q1.10 and the window w is zero before the first pixel of a line.
- R4: Outputs are clamped to the range −1024 to +1024 (−1.0 to +1.0). Both the negative clamp and the positive clamp apply.
- R5: The phase is bits [12:10] of a 13-bit accumulator fraction. After each output the 16-bit step is added. If the integer part of the sum is zero, another output comes from the same window; if it is n, n more pixels are taken before the next output.
- R6: With step 0x1000 (2× enlargement), each pixel yields two outputs whose phases alternate between the start phase and the start phase plus 4.
- R7: With step 0x4000, one output is made per two pixels, and with step 0x8000, one output per four pixels. The first output of a line always follows its first pixel.
- R8: The accumulator fraction is loaded from start_phase·1024 when the first pixel of a line is accepted. The first output of the line uses that phase.
- R9: After the outputs due on the pixel with in_last=1, the window is cleared, and the next line starts as after reset, with its coefficients kept.
- R10: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data stays stable. in_ready is 0 whenever out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Filter can accept a pixel |
| in_data | input | 12 | Input pixel, signed Q1.10 |
| in_last | input | 1 | Marks the last pixel of a line |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_data | output | 12 | Output sample, signed Q1.10, clamped to ±1.0 |
| step | input | 16 | Accumulator increment, 3.13 fixed point, held for a line |
| start_phase | input | 3 | Phase for the first output of a line |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 5 | Coefficient index: phase in [4:2], tap in [1:0] |
| cfg_data | input | 12 | Coefficient value, signed Q1.10 |

## Verification
The end of a line and the final output of that line fall in the same cycle. In that cycle the last output handshake is taken, and the line restart clears the window and arms the phase reload. The bench provokes this by sending lines back to back, with the next line's first pixel offered while the previous line's last outputs are still stalled by back-pressure. Correct behaviour is judged by the first outputs of the new line: they must equal the tap-0 product alone at the new start phase, with no residue from the old window or old phase.

// File: rtl/hps_pkg.sv
package hps_pkg;
    localparam int PIX_W_D    = 12;
    localparam int FRAC_W_D   = 10;
    localparam int TAPS_D     = 4;
    localparam int PHASES_D   = 8;
    localparam int ACC_W_D    = 16;
    localparam int ACC_FRAC_D = 13;

    typedef enum logic {
        ST_WAIT,
        ST_EMIT
    } hps_state_e;
endpackage

// File: rtl/hps_coef_bank.sv
module hps_coef_bank #(
    parameter int PW     = 12,
    parameter int TAPS   = 4,
    parameter int PHASES = 8,
    localparam int CA_W  = $clog2(PHASES * TAPS),
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CA_W-1:0]      addr,
    input  logic [PW-1:0]        wdata,
    input  logic [PH_W-1:0]      phase,
    output logic [TAPS*PW-1:0]   coefs
);
    localparam int DEPTH = PHASES * TAPS;

    logic [PW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_rd
        assign coefs[t*PW +: PW] = mem[int'(phase) * TAPS + t];
    end
endmodule

// File: rtl/hps_delay_line.sv
module hps_delay_line #(
    parameter int PW   = 12,
    parameter int TAPS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               shift,
    input  logic [PW-1:0]      din,
    output logic [TAPS*PW-1:0] win
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win <= '0;
        end else if (shift) begin
            win <= {win[(TAPS-1)*PW-1:0], din};
        end
    end
endmodule

// File: rtl/hps_mac_sat.sv
module hps_mac_sat #(
    parameter int PW   = 12,
    parameter int FRAC = 10,
    parameter int TAPS = 4
) (
    input  logic [TAPS*PW-1:0]   win,
    input  logic [TAPS*PW-1:0]   coefs,
    output logic signed [PW-1:0] y
);
    localparam int PROD_W = 2 * PW;
    localparam int SUM_W  = PROD_W + $clog2(TAPS);
    localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'(1) << FRAC;
    localparam logic signed [SUM_W-1:0] NEG_LIM = -POS_LIM;

    logic signed [PROD_W-1:0] prods [TAPS];
    logic signed [SUM_W-1:0]  acc;
    logic signed [SUM_W-1:0]  scaled;

    for (genvar t = 0; t < TAPS; t++) begin : g_mul
        assign prods[t] = $signed(win[t*PW +: PW]) * $signed(coefs[t*PW +: PW]);
    end

    always_comb begin
        acc = '0;
        for (int t = 0; t < TAPS; t++) begin
            acc = acc + SUM_W'(prods[t]);
        end
        scaled = acc >>> FRAC;
        if (scaled > POS_LIM) begin
            y = POS_LIM[PW-1:0];
        end else if (scaled < NEG_LIM) begin
            y = NEG_LIM[PW-1:0];
        end else begin
            y = scaled[PW-1:0];
        end
    end
endmodule

// File: rtl/hps_phase_ctrl.sv
module hps_phase_ctrl
    import hps_pkg::*;
#(
    parameter int ACC_W    = 16,
    parameter int ACC_FRAC = 13,
    parameter int PH_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             out_ready,
    input  logic [ACC_W-1:0] step,
    input  logic [PH_W-1:0]  start_phase,
    output logic             in_ready,
    output logic             out_valid,
    output logic             shift_en,
    output logic             clr_en,
    output logic [PH_W-1:0]  phase
);
    localparam int SKIP_W = ACC_W - ACC_FRAC;

    hps_state_e          state, nxt_state;
    logic [ACC_FRAC-1:0] frac, nxt_frac;
    logic [SKIP_W-1:0]   skip, nxt_skip;
    logic                eol_pend, nxt_eol;
    logic                fresh, nxt_fresh;
    logic                restart;
    logic [ACC_W-1:0]    sum;
    logic [ACC_FRAC-1:0] start_frac;

    assign sum        = {{SKIP_W{1'b0}}, frac} + step;
    assign start_frac = {start_phase, {(ACC_FRAC-PH_W){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_WAIT;
            frac     <= '0;
            skip     <= SKIP_W'(1);
            eol_pend <= 1'b0;
            fresh    <= 1'b1;
        end else begin
            state    <= nxt_state;
            frac     <= nxt_frac;
            skip     <= nxt_skip;
            eol_pend <= nxt_eol;
            fresh    <= nxt_fresh;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_frac  = frac;
        nxt_skip  = skip;
        nxt_eol   = eol_pend;
        nxt_fresh = fresh;
        restart   = 1'b0;
        unique case (state)
            ST_WAIT: begin
                if (in_valid) begin
                    if (fresh) nxt_frac = start_frac;
                    nxt_fresh = 1'b0;
                    if (skip == SKIP_W'(1)) begin
                        nxt_state = ST_EMIT;
                        nxt_eol   = in_last;
                    end else if (in_last) begin
                        restart = 1'b1;
                    end else begin
                        nxt_skip = skip - SKIP_W'(1);
                    end
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    nxt_frac = sum[ACC_FRAC-1:0];
                    if (sum[ACC_W-1:ACC_FRAC] != '0) begin
                        if (eol_pend) begin
                            restart = 1'b1;
                        end else begin
                            nxt_skip  = sum[ACC_W-1:ACC_FRAC];
                            nxt_state = ST_WAIT;
                        end
                    end
                end
            end
            default: nxt_state = ST_WAIT;
        endcase
        if (restart) begin
            nxt_state = ST_WAIT;
            nxt_skip  = SKIP_W'(1);
            nxt_fresh = 1'b1;
            nxt_eol   = 1'b0;
        end
    end

    always_comb begin
        in_ready  = (state == ST_WAIT);
        out_valid = (state == ST_EMIT);
        shift_en  = (state == ST_WAIT) && in_valid;
        clr_en    = restart;
        phase     = frac[ACC_FRAC-1 -: PH_W];
    end
endmodule

// File: rtl/hps_scaler.sv
module hps_scaler
    import hps_pkg::*;
#(
    parameter int PW       = PIX_W_D,
    parameter int FRAC     = FRAC_W_D,
    parameter int TAPS     = TAPS_D,
    parameter int PHASES   = PHASES_D,
    parameter int ACC_W    = ACC_W_D,
    parameter int ACC_FRAC = ACC_FRAC_D,
    localparam int PH_W    = $clog2(PHASES),
    localparam int CA_W    = $clog2(PHASES * TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PW-1:0]    in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PW-1:0]    out_data,
    input  logic [ACC_W-1:0] step,
    input  logic [PH_W-1:0]  start_phase,
    input  logic             cfg_we,
    input  logic [CA_W-1:0]  cfg_addr,
    input  logic [PW-1:0]    cfg_data
);
    logic               shift_en;
    logic               clr_en;
    logic [PH_W-1:0]    phase;
    logic [TAPS*PW-1:0] win;
    logic [TAPS*PW-1:0] coefs;
    logic signed [PW-1:0] y;

    hps_phase_ctrl #(.ACC_W(ACC_W), .ACC_FRAC(ACC_FRAC), .PH_W(PH_W)) ctrl_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .out_ready(out_ready), .step(step), .start_phase(start_phase),
        .in_ready(in_ready), .out_valid(out_valid), .shift_en(shift_en),
        .clr_en(clr_en), .phase(phase)
    );

    hps_delay_line #(.PW(PW), .TAPS(TAPS)) dly_i (
        .clk(clk), .rst(rst), .clr(clr_en), .shift(shift_en),
        .din(in_data), .win(win)
    );

    hps_coef_bank #(.PW(PW), .TAPS(TAPS), .PHASES(PHASES)) bank_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_data), .phase(phase), .coefs(coefs)
    );

    hps_mac_sat #(.PW(PW), .FRAC(FRAC), .TAPS(TAPS)) mac_i (
        .win(win), .coefs(coefs), .y(y)
    );

    assign out_data = y;
endmodule

// File: rtl/hps_scaler_chk.sv
module hps_scaler_chk #(
    parameter int PW   = 12,
    parameter int FRAC = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [PW-1:0] out_data,
    input logic          cfg_we
);
    localparam logic signed [PW-1:0] LIM = PW'(1) << FRAC;

    // R4: output never leaves the clamp range
    a_r4_clamp_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (($signed(out_data) <= LIM) && ($signed(out_data) >= -LIM)));

    // R10: stalled output is held
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !cfg_we) |=> (out_valid && $stable(out_data)));

    // R10: no input accepted while an output is pending
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R3: a valid output is always a known value
    a_r3_known_data: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_data));
endmodule

bind hps_scaler hps_scaler_chk #(.PW(PW), .FRAC(FRAC)) chk_i (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .cfg_we(cfg_we)
);

// File: tb/hps_scaler_tb_top.sv
module hps_scaler_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [11:0] out_data;
    logic [15:0] step = 16'h2000;
    logic [2:0]  start_phase = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [11:0] cfg_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit bp_en = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_stall = 1'b0;
    logic [11:0] prev_data = '0;

    int    cf [8][4];
    int    line_px[$];
    int    exp_q[$];
    string tag_q[$];
    string cur_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    hps_scaler dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .step(step),
        .start_phase(start_phase), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data)
    );

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int sx12(input logic [11:0] v);
        return int'($signed(v));
    endfunction

    // monitor: update ready first, then judge the handshake of the coming edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (prev_stall) check("R10 stall hold", out_valid ? sx12(out_data) : 9999, sx12(prev_data));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_en ? lfsr[0] : 1'b1;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected output", sx12(out_data), 9999);
                end else begin
                    check(tag_q.pop_front(), sx12(out_data), exp_q.pop_front());
                end
            end
        end
    end

    task automatic set_coef(input int p, input int t, input int v);
        @(negedge clk);
        cf[p][t] = v;
        cfg_we   = 1'b1;
        cfg_addr = 5'(p * 4 + t);
        cfg_data = 12'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int emit_val(input int ph, input int w0, input int w1, input int w2, input int w3);
        int a;
        a = cf[ph][0]*w0 + cf[ph][1]*w1 + cf[ph][2]*w2 + cf[ph][3]*w3;
        a = a >>> 10;
        if (a > 1024) a = 1024;
        if (a < -1024) a = -1024;
        return a;
    endfunction

    task automatic model_line(input int stp, input int st);
        int frac, skip, s;
        int w[4];
        frac = st * 1024;
        skip = 1;
        for (int i = 0; i < 4; i++) w[i] = 0;
        foreach (line_px[k]) begin
            w[3] = w[2]; w[2] = w[1]; w[1] = w[0]; w[0] = line_px[k];
            skip--;
            if (skip == 0) begin
                do begin
                    exp_q.push_back(emit_val(frac / 1024, w[0], w[1], w[2], w[3]));
                    tag_q.push_back(cur_tag);
                    s = frac + stp;
                    frac = s % 8192;
                    skip = s / 8192;
                end while (skip == 0);
            end
        end
    endtask

    task automatic drive_line();
        bit acc;
        foreach (line_px[k]) begin
            in_valid = 1'b1;
            in_data  = 12'(line_px[k]);
            in_last  = (k == line_px.size() - 1);
            acc = in_ready;
            @(negedge clk);
            while (!acc) begin
                acc = in_ready;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_line(input string tag, input int stp, input int st, input bit drain);
        @(negedge clk);
        cur_tag     = tag;
        step        = 16'(stp);
        start_phase = 3'(st);
        model_line(stp, st);
        drive_line();
        if (drain) begin
            while (exp_q.size() != 0) @(negedge clk);
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic fill_px(input int n, input int seed, input int span);
        line_px.delete();
        for (int k = 0; k < n; k++) line_px.push_back(((k * 173 + seed * 59) % (2 * span + 1)) - span);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 8; p++) for (int t = 0; t < 4; t++) cf[p][t] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 in_ready after reset", int'(in_ready), 1);
        check("R1 out_valid after reset", int'(out_valid), 0);
        fill_px(6, 1, 900);
        run_line("R1 zero coefficients", 16'h2000, 0, 1);

        // R3: passthrough on every phase
        for (int p = 0; p < 8; p++) set_coef(p, 0, 1024);
        fill_px(10, 2, 1000);
        run_line("R3 passthrough", 16'h2000, 0, 1);

        // R2: tap ordering and phase/tap addressing
        for (int p = 0; p < 8; p++) for (int t = 0; t < 4; t++)
            set_coef(p, t, ((p * 97 + t * 211) % 700) - 350);
        fill_px(12, 3, 1000);
        run_line("R2 general taps", 16'h2000, 3, 1);

        // R6: 2x enlargement, phases start and start+4
        fill_px(9, 4, 800);
        run_line("R6 upscale 2x", 16'h1000, 0, 1);
        fill_px(7, 5, 800);
        run_line("R6 upscale 2x start 2", 16'h1000, 2, 1);
        fill_px(5, 6, 800);
        run_line("R5 upscale 4x", 16'h0800, 1, 1);

        // R7: reduction
        fill_px(16, 7, 1000);
        run_line("R7 downscale 2", 16'h4000, 0, 1);
        fill_px(17, 8, 1000);
        run_line("R7 downscale 4", 16'h8000, 5, 1);

        // R5: non-integer ratios
        fill_px(20, 9, 1000);
        run_line("R5 step 0x1770", 16'h1770, 0, 1);
        fill_px(20, 10, 1000);
        run_line("R5 step 0x2AF8", 16'h2AF8, 6, 1);

        // R8: start phase walk
        for (int s = 0; s < 8; s++) begin
            fill_px(5, 11 + s, 1000);
            run_line("R8 start phase walk", 16'h2000, s, 1);
        end

        // R4: both clamps
        for (int p = 0; p < 8; p++) for (int t = 0; t < 4; t++) set_coef(p, t, 1024);
        line_px.delete();
        for (int k = 0; k < 6; k++) line_px.push_back(900);
        run_line("R4 positive clamp", 16'h2000, 0, 1);
        line_px.delete();
        for (int k = 0; k < 6; k++) line_px.push_back(-900);
        run_line("R4 negative clamp", 16'h2000, 0, 1);
        line_px.delete();
        for (int k = 0; k < 6; k++) line_px.push_back(-256);
        run_line("R4 exact minus one", 16'h2000, 0, 1);

        // R9 + R10: back-to-back lines under back-pressure
        for (int p = 0; p < 8; p++) for (int t = 0; t < 4; t++)
            set_coef(p, t, ((p * 131 + t * 57) % 600) - 300);
        bp_en = 1;
        fill_px(8, 20, 1000);
        run_line("R9 line A", 16'h1000, 1, 0);
        fill_px(6, 21, 1000);
        run_line("R9 line B restart", 16'h1000, 6, 0);
        fill_px(9, 22, 1000);
        run_line("R9 line C decimate", 16'h6000, 3, 0);
        fill_px(8, 23, 1000);
        run_line("R10 backpressure", 16'h1000, 0, 1);
        bp_en = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule